// File: doc/BRIEF.md
# Pulse-Width Capture Event Counter

This block is a single counter with two uses. In pulse-width mode it measures how long an external input stays at a chosen level. The measurement is counted in ticks of a prescaler that divides the system clock by a power of two between 4 and 1024. When the level ends, the count is copied to a capture register, the counter clears, and a one-cycle done flag is raised. In event mode the same counter counts qualified edges of an external input. It can count rising edges, falling edges, or both.

Each external input first passes through a two-flop synchronizer. It then passes through a level filter that accepts a new level only after three consecutive equal samples, so any pulse shorter than three system-clock periods is discarded. The filter and the prescaler together set the shortest measurable pulse, which is the larger of three clock periods and one prescaled tick. They also set the fastest countable event stream, which is one sixth of the system clock. The counter saturates at its maximum value and sets a sticky overflow flag.

Top module: `pwc_timer`

## Requirements
- R1: In pulse-width mode the counter advances once every D system clocks while the measured level is active, with D = 4 << cfg_presc (cfg_presc 0..8 gives 4..1024). A filtered active period of N clocks therefore captures floor(N/D).
- R2: A synchronized input level is accepted only after three consecutive equal samples. A pulse lasting 1 or 2 clocks is ignored, and a pulse lasting 3 clocks is accepted.
- R3: When the active level ends, capture takes the count, count returns to 0, and cap_done is 1 for exactly one cycle.
- R4: cfg_pin_sel = 0 measures pin_a and cfg_pin_sel = 1 measures pin_b. The unselected pin has no effect.
- R5: cfg_pol = 0 measures high pulses and cfg_pol = 1 measures low pulses.
- R6: In event mode (cfg_mode = 1) the counter adds 1 per qualified edge of pin_b. cfg_edge 0 counts rising edges, 1 counts falling edges, and 2 or 3 counts both edges. The count never moves by more than one per cycle.
- R7: The counter saturates at 2^CNT_W-1 and sets ovf. ovf stays set until a cycle with ovf_clr = 1, which clears it unless a new overflow occurs in the same cycle.
- R8: While enabled, a change of any configuration input (mode, prescaler, pin select, polarity, edge) clears the count and the prescaler at the next clock edge.
- R9: With cfg_en = 0 the count is held at 0, no capture occurs, and capture keeps its last value.
- R10: After reset, count, capture, cap_done and ovf are all 0.
- R11: cfg_presc values above 8 divide by 1024, the same as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Counter enable |
| cfg_mode | input | 1 | 0 pulse-width, 1 event count |
| cfg_presc | input | 4 | Prescaler select, divide by 4 << value |
| cfg_pin_sel | input | 1 | Pulse source: 0 pin_a, 1 pin_b |
| cfg_pol | input | 1 | Measured level: 0 high, 1 low |
| cfg_edge | input | 2 | Event edge: 0 rise, 1 fall, 2/3 both |
| pin_a | input | 1 | External input A, asynchronous |
| pin_b | input | 1 | External input B, asynchronous, also the event input |
| ovf_clr | input | 1 | Write-one-to-clear for ovf |
| count | output | CNT_W | Running count |
| capture | output | CNT_W | Last captured pulse width |
| cap_done | output | 1 | One-cycle capture strobe |
| ovf | output | 1 | Sticky saturation flag |

## Verification
A wrong filter window or synchronizer depth shifts both edges of a measured pulse or lets a glitch through. The filtered edges appear five clocks after an input change, and at a filter fault a glitch shows as an extra capture or event a few cycles after the stimulus. A wrong prescaler terminal value changes the count's step period, and the running count drifts from the reference within one prescaled tick. Corrupted configuration tracking or saturation state shows as a count that fails to clear one cycle after a configuration change, or as an ovf flag that drops or appears at the wrong moment. These faults are visible on the next clock.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int PRE_W   = 10;
    localparam int SEL_MAX = 8;

    typedef enum logic {
        MODE_PULSE = 1'b0,
        MODE_EVENT = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_BOTH  = 2'd2,
        EDGE_BOTHX = 2'd3
    } edge_e;

    typedef struct packed {
        logic       mode;
        logic [3:0] presc;
        logic       pin_sel;
        logic       pol;
        logic [1:0] edge_sel;
    } cfg_t;

    typedef struct packed {
        logic now;
        logic prev;
    } lvl_t;

    // terminal value of the prescaler counter for a select code
    function automatic logic [PRE_W-1:0] presc_last(input logic [3:0] sel);
        logic [3:0]  s;
        logic [10:0] div;
        s   = (sel > 4'(SEL_MAX)) ? 4'(SEL_MAX) : sel;
        div = 11'd4 << s;
        return PRE_W'(div - 11'd1);
    endfunction
endpackage

// File: rtl/pwc_filter.sv
module pwc_filter #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic lvl_d
);
    logic [1:0]         sync_q;
    logic [SAMPLES-2:0] hist_q;
    logic [SAMPLES-1:0] win;

    assign win = {hist_q, sync_q[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= '0;
            lvl    <= 1'b0;
            lvl_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], din};
            if (SAMPLES > 2) begin
                hist_q <= {hist_q[SAMPLES-3:0], sync_q[1]};
            end else begin
                hist_q <= sync_q[1];
            end
            if (&win) begin
                lvl <= 1'b1;
            end else if (~|win) begin
                lvl <= 1'b0;
            end
            lvl_d <= lvl;
        end
    end
endmodule

// File: rtl/pwc_prescaler.sv
module pwc_prescaler
    import pwc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [3:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] last;

    assign last = presc_last(sel);
    assign tick = run && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwc_counter.sv
module pwc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic             cap,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] cap_q,
    output logic             done_q,
    output logic             ovf_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;
    assign at_max = (count_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            cap_q   <= '0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            done_q <= cap;
            if (cap) begin
                cap_q   <= count_q;
                count_q <= '0;
            end else if (clr) begin
                count_q <= '0;
            end else if (inc && !at_max) begin
                count_q <= count_q + 1'b1;
            end
            if (inc && !clr && !cap && at_max) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer
    import pwc_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int FILT_SAMPLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_mode,
    input  logic [3:0]       cfg_presc,
    input  logic             cfg_pin_sel,
    input  logic             cfg_pol,
    input  logic [1:0]       cfg_edge,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture,
    output logic             cap_done,
    output logic             ovf
);
    localparam int NPIN = 2;

    cfg_t cfg_now;
    cfg_t cfg_prev;
    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] flt;
    logic [NPIN-1:0] flt_d;
    lvl_t meas;
    logic chg, active, pulse_end, run, tick;
    logic rise_b, fall_b, evt_hit, inc, cap;

    assign cfg_now = '{mode: cfg_mode, presc: cfg_presc, pin_sel: cfg_pin_sel,
                       pol: cfg_pol, edge_sel: cfg_edge};
    assign pins    = {pin_b, pin_a};

    // shadow of the configuration, used only to spot changes
    always_ff @(posedge clk) begin
        cfg_prev <= cfg_now;
    end

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_in
            pwc_filter #(.SAMPLES(FILT_SAMPLES)) u_flt (
                .clk   (clk),
                .rst   (rst),
                .din   (pins[g]),
                .lvl   (flt[g]),
                .lvl_d (flt_d[g])
            );
        end
    endgenerate

    assign chg    = cfg_en && (cfg_now != cfg_prev);
    assign active = cfg_en && !chg;

    assign meas.now  = flt[cfg_pin_sel]   ^ cfg_pol;
    assign meas.prev = flt_d[cfg_pin_sel] ^ cfg_pol;
    assign pulse_end = meas.prev && !meas.now;
    assign run       = active && (mode_e'(cfg_mode) == MODE_PULSE) && meas.now;

    pwc_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sel  (cfg_presc),
        .tick (tick)
    );

    assign rise_b = flt[1] && !flt_d[1];
    assign fall_b = !flt[1] && flt_d[1];

    always_comb begin
        unique case (edge_e'(cfg_edge))
            EDGE_RISE: evt_hit = rise_b;
            EDGE_FALL: evt_hit = fall_b;
            default:   evt_hit = rise_b || fall_b;
        endcase
    end

    assign inc = active && ((mode_e'(cfg_mode) == MODE_PULSE) ? tick : evt_hit);
    assign cap = active && (mode_e'(cfg_mode) == MODE_PULSE) && pulse_end;

    pwc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (!active),
        .inc     (inc),
        .cap     (cap),
        .ovf_clr (ovf_clr),
        .count_q (count),
        .cap_q   (capture),
        .done_q  (cap_done),
        .ovf_q   (ovf)
    );
endmodule

// File: rtl/pwc_timer_chk.sv
module pwc_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             cfg_mode,
    input logic [3:0]       cfg_presc,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] count,
    input logic             cap_done,
    input logic             ovf
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (count == '0 && !cap_done && !ovf)); // R10

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cap_done |=> !cap_done); // R3

    AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cap_done |-> (count == '0)); // R3

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> (count == '0 && !cap_done)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf); // R7

    AST_MODE_CHANGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_mode != $past(cfg_mode)) |=> (count == '0)); // R8

    AST_PRESC_CHANGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_presc != $past(cfg_presc)) |=> (count == '0)); // R8

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == '0 || count == CNT_W'($past(count) + 1'b1))); // R6
endmodule

bind pwc_timer pwc_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .cfg_mode  (cfg_mode),
    .cfg_presc (cfg_presc),
    .ovf_clr   (ovf_clr),
    .count     (count),
    .cap_done  (cap_done),
    .ovf       (ovf)
);

// File: tb/pwc_timer_tb.sv
module pwc_timer_tb;
    localparam int W   = 10;
    localparam int MAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0, cfg_mode = 1'b0, cfg_pin_sel = 1'b0, cfg_pol = 1'b0;
    logic [3:0] cfg_presc = 4'd0;
    logic [1:0] cfg_edge  = 2'd0;
    logic pin_a = 1'b0, pin_b = 1'b0, ovf_clr = 1'b0;
    logic [W-1:0] count, capture;
    logic cap_done, ovf;

    int checks = 0, failures = 0, ncap = 0, cyc_n = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    pwc_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_presc(cfg_presc), .cfg_pin_sel(cfg_pin_sel), .cfg_pol(cfg_pol),
        .cfg_edge(cfg_edge), .pin_a(pin_a), .pin_b(pin_b), .ovf_clr(ovf_clr),
        .count(count), .capture(capture), .cap_done(cap_done), .ovf(ovf)
    );

    task automatic chk(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_s1[2], m_s2[2], m_last[2], m_run[2], m_filt[2], m_fd[2];
    int m_cnt, m_cap, m_done, m_ovf, m_pc, m_pcfg;

    always @(posedge clk) begin
        int pv[2];
        int fo[2];
        int fdo[2];
        int cfgv, dv, lvl, plvl, rise, fall, evt, inc, setov, sel;
        pv[0] = pin_a; pv[1] = pin_b;
        cfgv = int'({cfg_mode, cfg_presc, cfg_pin_sel, cfg_pol, cfg_edge});
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_last[i] = 0; m_run[i] = 2;
                m_filt[i] = 0; m_fd[i] = 0;
            end
            m_cnt = 0; m_cap = 0; m_done = 0; m_ovf = 0; m_pc = 0;
            m_pcfg = cfgv;
        end else begin
            for (int i = 0; i < 2; i++) begin
                fo[i] = m_filt[i]; fdo[i] = m_fd[i];
            end
            dv = 4 << ((cfg_presc > 8) ? 8 : int'(cfg_presc));
            sel = int'(cfg_pin_sel);
            inc = 0; setov = 0; m_done = 0;
            if (!(cfg_en && cfgv == m_pcfg)) begin
                m_cnt = 0; m_pc = 0;
            end else if (!cfg_mode) begin
                lvl  = fo[sel]  ^ int'(cfg_pol);
                plvl = fdo[sel] ^ int'(cfg_pol);
                if (plvl == 1 && lvl == 0) begin
                    m_cap = m_cnt; m_cnt = 0; m_done = 1; m_pc = 0;
                end else if (lvl == 1) begin
                    if (m_pc == dv - 1) begin m_pc = 0; inc = 1; end
                    else m_pc++;
                end else begin
                    m_pc = 0;
                end
            end else begin
                m_pc = 0;
                rise = (fo[1] == 1 && fdo[1] == 0) ? 1 : 0;
                fall = (fo[1] == 0 && fdo[1] == 1) ? 1 : 0;
                if (cfg_edge == 2'd0) evt = rise;
                else if (cfg_edge == 2'd1) evt = fall;
                else evt = rise | fall;
                inc = evt;
            end
            if (inc == 1) begin
                if (m_cnt == MAX) setov = 1;
                else m_cnt++;
            end
            if (setov == 1) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            m_pcfg = cfgv;
            for (int i = 0; i < 2; i++) begin
                if (m_s2[i] == m_last[i]) begin
                    if (m_run[i] < 3) m_run[i]++;
                end else begin
                    m_run[i] = 1;
                end
                m_last[i] = m_s2[i];
                m_fd[i] = m_filt[i];
                if (m_run[i] >= 3) m_filt[i] = m_s2[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = pv[i];
            end
        end
    end

    always @(negedge clk) begin
        cyc_n++;
        if (!rst) begin
            chk(cur_req, "count", int'(count), m_cnt);
            chk(cur_req, "capture", int'(capture), m_cap);
            chk(cur_req, "cap_done", int'(cap_done), m_done);
            chk(cur_req, "ovf", int'(ovf), m_ovf);
            if (cap_done) ncap++;
        end
        if (cyc_n > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc_n);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pa(input int hi, input int lo);
        pin_a = 1'b1; cyc(hi); pin_a = 1'b0; cyc(lo);
    endtask

    task automatic pb(input int hi, input int lo);
        pin_b = 1'b1; cyc(hi); pin_b = 1'b0; cyc(lo);
    endtask

    initial begin
        int n0;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R10 reset state
        chk("R10", "count after reset", int'(count), 0);
        chk("R10", "capture after reset", int'(capture), 0);
        chk("R10", "ovf after reset", int'(ovf), 0);

        cur_req = "R1";
        cfg_en = 1'b1; cyc(5);
        n0 = ncap;
        pa(40, 20);
        chk("R1", "capture div4 40clk", int'(capture), 10);
        chk("R3", "one capture per pulse", ncap - n0, 1);
        chk("R3", "count cleared after capture", int'(count), 0);

        cfg_presc = 4'd2; cyc(5);
        pa(100, 20);
        chk("R1", "capture div16 100clk", int'(capture), 6);

        cur_req = "R2";
        cfg_presc = 4'd0; cyc(5);
        n0 = ncap;
        pa(2, 20);
        chk("R2", "2-clock glitch ignored", ncap - n0, 0);
        chk("R2", "capture unchanged by glitch", int'(capture), 6);
        pa(3, 20);
        chk("R2", "3-clock pulse accepted", ncap - n0, 1);
        chk("R2", "3-clock pulse width", int'(capture), 0);

        cur_req = "R4";
        cfg_pin_sel = 1'b1; cyc(5);
        n0 = ncap;
        pa(30, 20);
        chk("R4", "unselected pin_a ignored", ncap - n0, 0);
        pb(24, 20);
        chk("R4", "pin_b measured", int'(capture), 6);
        cfg_pin_sel = 1'b0; cyc(5);

        cur_req = "R5";
        pin_a = 1'b1; cyc(10);
        cfg_pol = 1'b1; cyc(10);
        pin_a = 1'b0; cyc(32);
        pin_a = 1'b1; cyc(20);
        chk("R5", "low pulse measured", int'(capture), 8);
        pin_a = 1'b0; cyc(10);
        cfg_pol = 1'b0; cyc(10);

        cur_req = "R11";
        cfg_presc = 4'd12; cyc(5);
        pa(2100, 20);
        chk("R11", "select 12 acts as 1024", int'(capture), 2);

        cur_req = "R8";
        cfg_presc = 4'd0; cyc(5);
        pin_a = 1'b1; cyc(30);
        chk("R8", "count before change", int'(count), 6);
        cfg_presc = 4'd1; cyc(1);
        chk("R8", "count after prescaler change", int'(count), 0);
        pin_a = 1'b0; cyc(20);

        cur_req = "R7";
        cfg_presc = 4'd0; cyc(5);
        pin_a = 1'b1; cyc(4200);
        chk("R7", "count saturates", int'(count), MAX);
        chk("R7", "ovf set", int'(ovf), 1);
        pin_a = 1'b0; cyc(20);
        chk("R7", "saturated capture", int'(capture), MAX);
        chk("R7", "ovf still set", int'(ovf), 1);
        ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
        chk("R7", "ovf cleared", int'(ovf), 0);

        cur_req = "R9";
        cfg_en = 1'b0; cyc(5);
        n0 = ncap;
        pa(40, 20);
        chk("R9", "no capture while disabled", ncap - n0, 0);
        chk("R9", "capture retained", int'(capture), MAX);
        chk("R9", "count held at zero", int'(count), 0);

        cur_req = "R6";
        cfg_en = 1'b1; cfg_mode = 1'b1; cfg_edge = 2'd0; cyc(10);
        for (int k = 0; k < 5; k++) pb(6, 6);
        cyc(10);
        chk("R6", "rising edges counted", int'(count), 5);
        cfg_edge = 2'd1; cyc(10);
        for (int k = 0; k < 5; k++) pb(6, 6);
        cyc(10);
        chk("R6", "falling edges counted", int'(count), 5);
        cfg_edge = 2'd2; cyc(10);
        for (int k = 0; k < 5; k++) pb(6, 6);
        cyc(10);
        chk("R6", "both edges counted", int'(count), 10);
        cur_req = "R2";
        pb(2, 20);
        chk("R2", "event glitch ignored", int'(count), 10);
        pb(3, 20);
        chk("R2", "3-clock event accepted", int'(count), 12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule